// File: doc/BRIEF.md
# Bounded Tagged Message Mailbox

A single-clock, bounded first-in first-out store for short messages. Each message is a data word paired with a small type tag. A producer offers a message with a non-blocking put request. A consumer asks for the oldest message with a non-blocking get request, which removes it, or a peek request, which copies it and leaves it in place. Either read names the tag it expects. Neither side ever stalls. Every request is answered with a two-bit status code on the clock edge that accepts it.

The read status has three outcomes. 2'b01 means success. 2'b00 means the store is empty. 2'b11 means the oldest message carries a different tag. A tag mismatch leaves the store exactly as it was. The block also reports how many messages it holds, and it has full and empty flags. Capacity, data width and tag width are parameters.

Top module: `tag_mailbox`

## Requirements
- R1: Capacity `DEPTH` is set at instantiation. The default is 8. A capacity of 5, which is not a power of two, behaves the same way, with the bound at 5.
- R2: A put while not full stores the message behind all earlier ones. `putStatus` is 2'b01 in the cycle after the request. In any cycle after a cycle without a put request, `putStatus` is 2'b00.
- R3: A put while full, with no successful get in the same cycle, discards the message. `putStatus` is 2'b00 and the count is unchanged.
- R4: A get or peek while empty gives `readStatus` 2'b00 and leaves `outValid` low. A put in the same cycle does not satisfy it, but the put is still stored. In any cycle after a cycle without a read request, `readStatus` is 2'b00.
- R5: A get while not empty, whose requested tag equals the oldest message's tag, presents that message on `outData`/`outTag`. It pulses `outValid`, removes the message and gives `readStatus` 2'b01.
- R6: A get or peek whose tag differs from the oldest message's tag gives `readStatus` 2'b11. Nothing is removed, `outValid` stays low and `outData`/`outTag` keep their previous values.
- R7: A peek uses the same three outcomes as a get. On success it presents a copy of the oldest message and pulses `outValid`, and the message stays stored.
- R8: `msgCount` always equals the number of stored messages, from 0 to `DEPTH`. `isFull` is high exactly when the count is `DEPTH`, and `isEmpty` is high exactly when it is 0.
- R9: Messages leave in the order they were stored.
- R10: When the store is full, a put is accepted in a cycle where a get succeeds. The count then stays at `DEPTH`.
- R11: While `rstN` is low at a clock edge, the store empties. The count, both status outputs, `outValid`, `opError` and `outData`/`outTag` clear to zero.
- R12: A get and a peek requested in the same cycle is illegal. The get is carried out, and `opError` is high for that one following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| putReq | input | 1 | Put request this cycle |
| putData | input | DATA_W | Data word of the offered message |
| putTag | input | TAG_W | Tag of the offered message |
| getReq | input | 1 | Destructive read request |
| peekReq | input | 1 | Non-destructive read request |
| wantTag | input | TAG_W | Tag expected by the read |
| putStatus | output | 2 | Result of the last cycle's put |
| readStatus | output | 2 | Result of the last cycle's get or peek |
| outValid | output | 1 | Message delivered on outData/outTag |
| outData | output | DATA_W | Delivered data word |
| outTag | output | TAG_W | Delivered tag |
| msgCount | output | $clog2(DEPTH+1) | Messages held |
| isFull | output | 1 | Count equals DEPTH |
| isEmpty | output | 1 | Count is zero |
| opError | output | 1 | Get and peek were requested together |

## Verification
Every result is registered, so all of them are due one clock edge after the request: the statuses, the delivered message, `outValid`, `opError`, the count and both flags. The bench drives a request on a falling edge. It steps a queue-based model at the rising edge that accepts the request, and compares all outputs on the next falling edge. Instances with capacity 8 and capacity 5 share the same stimulus, and each has its own model. That stimulus includes directed fills past the bound, tag mismatches, peeks, puts and gets in the same cycle at both extremes, get with peek, and a reset in mid-run, followed by a long random mix.

// File: rtl/tag_mailbox_pkg.sv
package tag_mailbox_pkg;

  typedef enum logic [1:0] {
    ST_NONE     = 2'b00,
    ST_OK       = 2'b01,
    ST_MISMATCH = 2'b11
  } status_e;

  // strobes from control to datapath
  typedef struct packed {
    logic push;   // write the offered message at the tail
    logic pop;    // drop the head message
    logic load;   // copy the head message into the output register
  } ctrlStrobes_t;

endpackage

// File: rtl/tag_mailbox_dp.sv
module tag_mailbox_dp
  import tag_mailbox_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 16,
  parameter int TAG_W  = 3
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  ctrlStrobes_t                   strb,
  input  logic [DATA_W-1:0]              putData,
  input  logic [TAG_W-1:0]               putTag,
  output logic [TAG_W-1:0]               headTag,
  output logic [DATA_W-1:0]              outData,
  output logic [TAG_W-1:0]               outTag,
  output logic [$clog2(DEPTH+1)-1:0]     count,
  output logic                           full,
  output logic                           empty
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam bit POW2  = (DEPTH & (DEPTH - 1)) == 0;
  localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(DEPTH);

  logic [DATA_W-1:0] dataMem [DEPTH];
  logic [TAG_W-1:0]  tagMem  [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr, wrNext, rdNext;

  // pointer wrap: free wrap for powers of two, compare otherwise
  generate
    if (POW2) begin : g_wrapFree
      assign wrNext = wrPtr + 1'b1;
      assign rdNext = rdPtr + 1'b1;
    end else begin : g_wrapCmp
      assign wrNext = (wrPtr == LAST_IDX) ? '0 : wrPtr + 1'b1;
      assign rdNext = (rdPtr == LAST_IDX) ? '0 : rdPtr + 1'b1;
    end
  endgenerate

  // storage entries
  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
      always_ff @(posedge clk) begin
        if (strb.push && (wrPtr == PTR_W'(i))) begin
          dataMem[i] <= putData;
          tagMem[i]  <= putTag;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (strb.push) wrPtr <= wrNext;
      if (strb.pop)  rdPtr <= rdNext;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count <= '0;
    end else begin
      case ({strb.push, strb.pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outData <= '0;
      outTag  <= '0;
    end else if (strb.load) begin
      outData <= dataMem[rdPtr];
      outTag  <= tagMem[rdPtr];
    end
  end

  assign headTag = tagMem[rdPtr];
  assign full    = (count == CNT_MAX);
  assign empty   = (count == '0);

endmodule

// File: rtl/tag_mailbox_ctrl.sv
module tag_mailbox_ctrl
  import tag_mailbox_pkg::*;
#(
  parameter int TAG_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             putReq,
  input  logic             getReq,
  input  logic             peekReq,
  input  logic [TAG_W-1:0] wantTag,
  input  logic [TAG_W-1:0] headTag,
  input  logic             full,
  input  logic             empty,
  output ctrlStrobes_t     strb,
  output logic [1:0]       putStatus,
  output logic [1:0]       readStatus,
  output logic             outValid,
  output logic             opError
);

  logic    readReq, tagHit, readOk, getOk, putOk;
  status_e readNext, putNext;

  assign readReq = getReq | peekReq;
  assign tagHit  = (headTag == wantTag);
  assign readOk  = readReq & ~empty & tagHit;
  assign getOk   = getReq & ~empty & tagHit;   // get wins over peek
  assign putOk   = putReq & (~full | getOk);

  always_comb begin
    if (!readReq || empty) readNext = ST_NONE;
    else if (!tagHit)      readNext = ST_MISMATCH;
    else                   readNext = ST_OK;
    putNext = putOk ? ST_OK : ST_NONE;
  end

  always_comb begin
    strb.push = putOk;
    strb.pop  = getOk;
    strb.load = readOk;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      putStatus  <= 2'b00;
      readStatus <= 2'b00;
      outValid   <= 1'b0;
      opError    <= 1'b0;
    end else begin
      putStatus  <= putNext;
      readStatus <= readNext;
      outValid   <= readOk;
      opError    <= getReq & peekReq;
    end
  end

endmodule

// File: rtl/tag_mailbox.sv
module tag_mailbox
  import tag_mailbox_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 16,
  parameter int TAG_W  = 3
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       putReq,
  input  logic [DATA_W-1:0]          putData,
  input  logic [TAG_W-1:0]           putTag,
  input  logic                       getReq,
  input  logic                       peekReq,
  input  logic [TAG_W-1:0]           wantTag,
  output logic [1:0]                 putStatus,
  output logic [1:0]                 readStatus,
  output logic                       outValid,
  output logic [DATA_W-1:0]          outData,
  output logic [TAG_W-1:0]           outTag,
  output logic [$clog2(DEPTH+1)-1:0] msgCount,
  output logic                       isFull,
  output logic                       isEmpty,
  output logic                       opError
);

  ctrlStrobes_t     strb;
  logic [TAG_W-1:0] headTag;

  tag_mailbox_ctrl #(.TAG_W(TAG_W)) ctrl_i (
    .clk(clk), .rstN(rstN),
    .putReq(putReq), .getReq(getReq), .peekReq(peekReq), .wantTag(wantTag),
    .headTag(headTag), .full(isFull), .empty(isEmpty),
    .strb(strb), .putStatus(putStatus), .readStatus(readStatus),
    .outValid(outValid), .opError(opError)
  );

  tag_mailbox_dp #(.DEPTH(DEPTH), .DATA_W(DATA_W), .TAG_W(TAG_W)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb),
    .putData(putData), .putTag(putTag),
    .headTag(headTag), .outData(outData), .outTag(outTag),
    .count(msgCount), .full(isFull), .empty(isEmpty)
  );

endmodule

// File: rtl/tag_mailbox_chk.sv
module tag_mailbox_chk #(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 16,
  parameter int TAG_W  = 3
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       putReq,
  input logic                       getReq,
  input logic                       peekReq,
  input logic [1:0]                 putStatus,
  input logic [1:0]                 readStatus,
  input logic                       outValid,
  input logic [DATA_W-1:0]          outData,
  input logic [$clog2(DEPTH+1)-1:0] msgCount,
  input logic                       isFull,
  input logic                       isEmpty,
  input logic                       opError
);

  assert_count_bound_R8: assert property (@(posedge clk) disable iff (!rstN)
    msgCount <= ($clog2(DEPTH+1))'(DEPTH));

  assert_flags_exclusive_R8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({isFull, isEmpty}));

  assert_put_accept_R2: assert property (@(posedge clk) disable iff (!rstN)
    putReq && !isFull |=> putStatus == 2'b01);

  assert_put_drop_R3: assert property (@(posedge clk) disable iff (!rstN)
    putReq && isFull && !getReq |=> putStatus == 2'b00 && $stable(msgCount));

  assert_get_empty_R4: assert property (@(posedge clk) disable iff (!rstN)
    getReq && isEmpty |=> readStatus == 2'b00 && !outValid);

  assert_mismatch_quiet_R6: assert property (@(posedge clk) disable iff (!rstN)
    readStatus == 2'b11 |-> !outValid && $stable(outData));

  assert_peek_keeps_R7: assert property (@(posedge clk) disable iff (!rstN)
    peekReq && !getReq && !putReq |=> $stable(msgCount));

  assert_dual_read_flag_R12: assert property (@(posedge clk) disable iff (!rstN)
    getReq && peekReq |=> opError);

endmodule

bind tag_mailbox tag_mailbox_chk #(.DEPTH(DEPTH), .DATA_W(DATA_W), .TAG_W(TAG_W)) chk_i (
  .clk(clk), .rstN(rstN), .putReq(putReq), .getReq(getReq), .peekReq(peekReq),
  .putStatus(putStatus), .readStatus(readStatus), .outValid(outValid),
  .outData(outData), .msgCount(msgCount), .isFull(isFull), .isEmpty(isEmpty),
  .opError(opError)
);

// File: tb/tag_mailbox_tb_top.sv
module tag_mailbox_tb_top;

  localparam int DW = 16;
  localparam int TW = 3;

  typedef struct packed {
    logic [TW-1:0] tag;
    logic [DW-1:0] data;
  } msg_t;

  typedef msg_t msgQ_t[$];

  typedef struct {
    int putSt;
    int rdSt;
    int valid;
    int data;
    int tag;
    int count;
    int full;
    int empty;
    int err;
  } exp_t;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          putReq = 1'b0, getReq = 1'b0, peekReq = 1'b0;
  logic [DW-1:0] putData = '0;
  logic [TW-1:0] putTag = '0, wantTag = '0;

  logic [1:0]    pSt8, rSt8, pSt5, rSt5;
  logic          val8, val5, full8, full5, emp8, emp5, err8, err5;
  logic [DW-1:0] dat8, dat5;
  logic [TW-1:0] tag8, tag5;
  logic [3:0]    cnt8;
  logic [2:0]    cnt5;

  int checks = 0;
  int fails  = 0;

  msgQ_t q8, q5;
  exp_t  e8, e5;

  always #5 clk = ~clk;

  tag_mailbox #(.DEPTH(8), .DATA_W(DW), .TAG_W(TW)) dut_i (
    .clk(clk), .rstN(rstN), .putReq(putReq), .putData(putData), .putTag(putTag),
    .getReq(getReq), .peekReq(peekReq), .wantTag(wantTag),
    .putStatus(pSt8), .readStatus(rSt8), .outValid(val8), .outData(dat8),
    .outTag(tag8), .msgCount(cnt8), .isFull(full8), .isEmpty(emp8), .opError(err8)
  );

  tag_mailbox #(.DEPTH(5), .DATA_W(DW), .TAG_W(TW)) dut5_i (
    .clk(clk), .rstN(rstN), .putReq(putReq), .putData(putData), .putTag(putTag),
    .getReq(getReq), .peekReq(peekReq), .wantTag(wantTag),
    .putStatus(pSt5), .readStatus(rSt5), .outValid(val5), .outData(dat5),
    .outTag(tag5), .msgCount(cnt5), .isFull(full5), .isEmpty(emp5), .opError(err5)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // behavioural model of one request cycle
  task automatic model(input int depth, inout msgQ_t q, inout exp_t e);
    bit rd, hit, getOk, putOk;
    if (!rstN) begin
      q.delete();
      e = '{default: 0};
      e.empty = 1;
      return;
    end
    rd    = getReq || peekReq;
    hit   = (q.size() > 0) && (q[0].tag == wantTag);
    getOk = getReq && hit;
    putOk = putReq && ((q.size() < depth) || getOk);
    e.rdSt  = !rd ? 0 : (q.size() == 0) ? 0 : hit ? 1 : 3;
    e.putSt = putOk ? 1 : 0;
    e.valid = (rd && hit) ? 1 : 0;
    if (rd && hit) begin
      e.data = int'(q[0].data);
      e.tag  = int'(q[0].tag);
    end
    e.err = (getReq && peekReq) ? 1 : 0;
    if (getOk) void'(q.pop_front());
    if (putOk) q.push_back('{tag: putTag, data: putData});
    e.count = q.size();
    e.full  = (q.size() == depth) ? 1 : 0;
    e.empty = (q.size() == 0) ? 1 : 0;
  endtask

  task automatic compareAll();
    // capacity-8 instance
    chk("R2 R3 R10", "putStatus", int'(pSt8), e8.putSt);
    chk("R4 R5 R6 R7", "readStatus", int'(rSt8), e8.rdSt);
    chk("R5 R7", "outValid", int'(val8), e8.valid);
    chk("R5 R9", "outData", int'(dat8), e8.data);
    chk("R5 R9", "outTag", int'(tag8), e8.tag);
    chk("R8", "msgCount", int'(cnt8), e8.count);
    chk("R8", "isFull", int'(full8), e8.full);
    chk("R8", "isEmpty", int'(emp8), e8.empty);
    chk("R12", "opError", int'(err8), e8.err);
    // capacity-5 instance
    chk("R1", "putStatus5", int'(pSt5), e5.putSt);
    chk("R1", "readStatus5", int'(rSt5), e5.rdSt);
    chk("R1", "outValid5", int'(val5), e5.valid);
    chk("R1 R9", "outData5", int'(dat5), e5.data);
    chk("R1 R9", "outTag5", int'(tag5), e5.tag);
    chk("R1", "msgCount5", int'(cnt5), e5.count);
    chk("R1", "isFull5", int'(full5), e5.full);
    chk("R1", "isEmpty5", int'(emp5), e5.empty);
    chk("R1", "opError5", int'(err5), e5.err);
  endtask

  // one clock: drive at falling edge, model at rising, compare at next falling
  task automatic cyc(input bit put, input int pTag, input int pData,
                     input bit get, input bit peek, input int wTag);
    putReq  = put;
    putTag  = TW'(pTag);
    putData = DW'(pData);
    getReq  = get;
    peekReq = peek;
    wantTag = TW'(wTag);
    @(posedge clk);
    model(8, q8, e8);
    model(5, q5, e5);
    @(negedge clk);
    compareAll();
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : stim
    @(negedge clk);
    // R11: reset state
    rstN = 1'b0;
    repeat (3) cyc(0, 0, 0, 0, 0, 0);
    rstN = 1'b1;

    // R4: read of an empty store, with a put in the same cycle
    cyc(0, 0, 0, 1, 0, 0);
    cyc(1, 2, 16'h1111, 1, 0, 2);
    cyc(0, 0, 0, 0, 1, 1);            // R6 peek with the wrong tag
    cyc(0, 0, 0, 0, 1, 2);            // R7 peek hit
    cyc(0, 0, 0, 1, 0, 2);            // R5 get hit

    // R2 R3 R1: fill past both bounds
    for (int i = 0; i < 10; i++) cyc(1, i % 4, 16'h0A00 + i, 0, 0, 0);
    // R10: full put together with a successful get (head tag 0)
    cyc(1, 5, 16'hBEEF, 1, 0, 0);
    // R3: full put together with a get that misses
    cyc(1, 6, 16'hDEAD, 1, 0, 7);
    // R12: get and peek together
    cyc(0, 0, 0, 1, 1, 1);
    cyc(0, 0, 0, 1, 1, 0);
    // R9: drain in order
    for (int i = 0; i < 12; i++) cyc(0, 0, 0, 1, 0, (q8.size() > 0) ? int'(q8[0].tag) : 0);

    // R11: reset in the middle of traffic
    for (int i = 0; i < 4; i++) cyc(1, i, 16'h5500 + i, 0, 0, 0);
    rstN = 1'b0;
    cyc(1, 1, 16'h7777, 1, 0, 0);
    rstN = 1'b1;
    cyc(0, 0, 0, 1, 0, 0);

    // random mix
    for (int i = 0; i < 4000; i++) begin
      int r, wt;
      r  = int'($urandom_range(0, 99));
      wt = (q8.size() > 0 && $urandom_range(0, 3) != 0) ? int'(q8[0].tag)
                                                        : int'($urandom_range(0, 3));
      cyc(r < 55, int'($urandom_range(0, 3)), int'($urandom_range(0, 65535)),
          (r % 3) == 0, (r % 5) == 1, wt);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule